// File: doc/BRIEF.md
# NAND Controller Host Register Front-End

This block is the register face that a host processor sees on a small NAND flash controller. Every host write of a command, address, write-data or read-request word lands in one shared write buffer of four entries. Each entry is tagged with its kind. A downstream cycle sequencer drains the entries in order and turns them into bus cycles. A read is requested by writing any value to the read-request register. When the sequencer later hands back the fetched word, it is latched in a read register and a sticky ready flag is raised.

The block also holds the controller configuration: page size, bus width and the two strobe delays. It launches page read and page write bursts from a page-control register and tracks whether each burst is still pending. A self-clearing bit starts a fixed-length clear pulse for the ECC accumulators and transfer counters. Five sticky event flags can each be cleared by writing 1 to them, and a mask combines them into one interrupt line. Register reads are combinational on the current address, and register writes take effect at the clock edge.

Top module: `nfc_host_regs`

## Requirements
- R1: After reset the status register reads 0x0010 (buffer empty, device busy), the interrupt status register reads 0, the interrupt line is low, the control register reads 0x0001 and no cycle is offered to the sequencer.
- R2: Writes to offsets 4, 5, 6 and 7 (command, address, write data, read request) each push one entry tagged 0, 1, 2 or 3 respectively, carrying the written word. The sequencer sees the oldest entry on cyc_tag/cyc_data while cyc_valid is high, and a cycle with cyc_pop high removes it.
- R3: Status bit1 is high when the buffer holds 4 entries and bit4 is high when it holds none. A push while full is dropped, even if a pop happens in the same cycle, and it sets interrupt status bit1 (overflow).
- R4: Interrupt status bit2 sets when a pop empties the buffer and no push happens in the same cycle.
- R5: A cycle with rd_valid high stores rd_word into the read register at offset 8 and sets interrupt status bit3.
- R6: Writing the interrupt status register (offset 2) clears each bit written as 1 and leaves bits written as 0. A set event in the same cycle wins over the clear.
- R7: irq is high exactly when some interrupt status bit is set whose bit in the mask register (offset 3) is also set.
- R8: Status bit0 follows dev_rdy one cycle later. A rise of dev_rdy sets interrupt status bit0.
- R9: Writing page control (offset 10) with bit0 set pulses pg_rd_go for one cycle and sets status bit3 until pg_rd_done. Writing it with bit1 set pulses pg_wr_go and sets status bit2 until pg_wr_done, and pg_wr_done then sets interrupt status bit4.
- R10: Writing 1 to bit0 of offset 9 makes that bit read 1 and raises ecc_clr for exactly RST_CYCLES cycles (default 4). Then both clear by themselves.
- R11: The control register (offset 0) is read/write with bit0 = 512-byte page, bit1 = 16-bit bus, bits 7:4 = read strobe delay and bits 11:8 = write strobe delay. It drives the cfg_* outputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register read data for host_addr |
| irq | output | 1 | Masked interrupt line |
| dev_rdy | input | 1 | Flash ready/busy line, high when ready |
| cyc_valid | output | 1 | Buffer head entry is valid |
| cyc_tag | output | 2 | Kind of head entry |
| cyc_data | output | 16 | Word of head entry |
| cyc_pop | input | 1 | Sequencer consumes the head entry |
| rd_valid | input | 1 | Sequencer returns a read word |
| rd_word | input | 16 | Returned read word |
| pg_rd_go | output | 1 | One-cycle page read launch |
| pg_wr_go | output | 1 | One-cycle page write launch |
| pg_rd_done | input | 1 | Page read burst finished |
| pg_wr_done | input | 1 | Page write burst finished |
| ecc_clr | output | 1 | ECC and counter clear pulse |
| cfg_page512 | output | 1 | 512-byte page select |
| cfg_wide | output | 1 | 16-bit bus select |
| cfg_rd_dly | output | 4 | Read strobe delay |
| cfg_wr_dly | output | 4 | Write strobe delay |

## Verification
Every write, pop and sequencer event is registered at one clock edge, and its effect is visible on host_rdata, the cycle outputs, irq and the go pulses in the same cycle after that edge. Register reads have no latency. The bench drives inputs at the falling edge, lets one rising edge pass, and samples at the following falling edge, so each check looks exactly one edge after its stimulus. The exception is the ecc_clr pulse, which the bench counts edge by edge to confirm that it stays high for RST_CYCLES cycles and drops on the next edge.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [1:0] {
    TAG_CMD  = 2'd0,
    TAG_ADDR = 2'd1,
    TAG_DWR  = 2'd2,
    TAG_DRD  = 2'd3
  } cyc_tag_e;

  localparam logic [3:0] OFS_CTRL   = 4'd0;
  localparam logic [3:0] OFS_STAT   = 4'd1;
  localparam logic [3:0] OFS_ISTAT  = 4'd2;
  localparam logic [3:0] OFS_IMASK  = 4'd3;
  localparam logic [3:0] OFS_RDWORD = 4'd8;
  localparam logic [3:0] OFS_RSTCTL = 4'd9;
  localparam logic [3:0] OFS_PGCTL  = 4'd10;

  localparam int NFLAGS = 5;

  localparam int EV_NBUSY = 0;
  localparam int EV_OVF   = 1;
  localparam int EV_DRAIN = 2;
  localparam int EV_RDRDY = 3;
  localparam int EV_WRDONE = 4;

  // the four push offsets occupy 4..7, the low two bits give the tag
  function automatic logic is_push_ofs(input logic [3:0] a);
    return a[3:2] == 2'b01;
  endfunction

  function automatic logic any_masked(input logic [NFLAGS-1:0] f,
                                      input logic [NFLAGS-1:0] m);
    return |(f & m);
  endfunction

  function automatic logic at_capacity(input int unsigned cnt,
                                       input int unsigned depth);
    return cnt >= depth;
  endfunction

endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [1:0]    push_tag,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          head_valid,
  output logic [1:0]    head_tag,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          drained
);
  import nfc_pkg::*;

  logic [1:0]    tag_mem  [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = at_capacity(32'(count), DEPTH);
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign ovf     = push & full;
  assign drained = do_pop & ~do_push & (count == CW'(1));

  assign head_valid = ~empty;
  assign head_tag   = tag_mem[rp];
  assign head_data  = data_mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) begin
      tag_mem[wp]  <= push_tag;
      data_mem[wp] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wrap_inc(wp);
      if (do_pop)  rp <= wrap_inc(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/nfc_irq.sv
module nfc_irq #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic          clr_we,
  input  logic [NF-1:0] clr_bits,
  input  logic          mask_we,
  input  logic [NF-1:0] mask_wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] mask,
  output logic          irq
);
  import nfc_pkg::*;

  logic [NF-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  generate
    for (genvar i = 0; i < NF; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flags[i] <= 1'b0;
        else if (set_ev[i]) flags[i] <= 1'b1;
        else if (clr_eff[i]) flags[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  assign irq = any_masked(flags, mask);

endmodule

// File: rtl/nfc_rstseq.sv
module nfc_rstseq #(
  parameter int CYCLES = 4,
  localparam int CNTW  = $clog2(CYCLES) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CNTW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (busy) begin
      if (left == '0) busy <= 1'b0;
      else            left <= left - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      left <= CNTW'(CYCLES - 1);
    end
  end

endmodule

// File: rtl/nfc_host_regs.sv
module nfc_host_regs #(
  parameter int DEPTH      = 4,
  parameter int RST_CYCLES = 4,
  localparam int DW        = 16,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [3:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          irq,
  input  logic          dev_rdy,
  output logic          cyc_valid,
  output logic [1:0]    cyc_tag,
  output logic [DW-1:0] cyc_data,
  input  logic          cyc_pop,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_word,
  output logic          pg_rd_go,
  output logic          pg_wr_go,
  input  logic          pg_rd_done,
  input  logic          pg_wr_done,
  output logic          ecc_clr,
  output logic          cfg_page512,
  output logic          cfg_wide,
  output logic [3:0]    cfg_rd_dly,
  output logic [3:0]    cfg_wr_dly
);
  import nfc_pkg::*;

  // named internal events, also observed by the checker
  logic              push_req;
  logic              wb_full, wb_empty;
  logic [CW-1:0]     wb_count;
  logic              ovf_ev, drain_ev;
  logic              nbusy_ev, wrdone_ev;
  logic              dev_q;
  logic              rst_start, rst_busy;
  logic              pg_we;
  logic              rd_pend, wr_pend;
  logic              istat_we;
  logic [NFLAGS-1:0] irq_flags, irq_mask, set_ev;
  logic [DW-1:0]     rd_hold;
  logic [11:0]       ctrl_q;

  assign push_req  = host_wr & is_push_ofs(host_addr);
  assign istat_we  = host_wr & (host_addr == OFS_ISTAT);
  assign pg_we     = host_wr & (host_addr == OFS_PGCTL);
  assign rst_start = host_wr & (host_addr == OFS_RSTCTL) & host_wdata[0];

  nfc_wbuf #(.DEPTH(DEPTH), .DW(DW)) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push_req),
    .push_tag   (host_addr[1:0]),
    .push_data  (host_wdata),
    .pop        (cyc_pop),
    .head_valid (cyc_valid),
    .head_tag   (cyc_tag),
    .head_data  (cyc_data),
    .full       (wb_full),
    .empty      (wb_empty),
    .count      (wb_count),
    .ovf        (ovf_ev),
    .drained    (drain_ev)
  );

  // ready/busy sampling and page bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q    <= 1'b0;
      rd_pend  <= 1'b0;
      wr_pend  <= 1'b0;
      pg_rd_go <= 1'b0;
      pg_wr_go <= 1'b0;
    end else begin
      dev_q    <= dev_rdy;
      pg_rd_go <= pg_we & host_wdata[0];
      pg_wr_go <= pg_we & host_wdata[1];
      if (pg_we & host_wdata[0]) rd_pend <= 1'b1;
      else if (pg_rd_done)       rd_pend <= 1'b0;
      if (pg_we & host_wdata[1]) wr_pend <= 1'b1;
      else if (pg_wr_done)       wr_pend <= 1'b0;
    end
  end

  assign nbusy_ev  = dev_rdy & ~dev_q;
  assign wrdone_ev = pg_wr_done & wr_pend;

  always_comb begin
    set_ev             = '0;
    set_ev[EV_NBUSY]   = nbusy_ev;
    set_ev[EV_OVF]     = ovf_ev;
    set_ev[EV_DRAIN]   = drain_ev;
    set_ev[EV_RDRDY]   = rd_valid;
    set_ev[EV_WRDONE]  = wrdone_ev;
  end

  nfc_irq #(.NF(NFLAGS)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_ev     (set_ev),
    .clr_we     (istat_we),
    .clr_bits   (host_wdata[NFLAGS-1:0]),
    .mask_we    (host_wr & (host_addr == OFS_IMASK)),
    .mask_wdata (host_wdata[NFLAGS-1:0]),
    .flags      (irq_flags),
    .mask       (irq_mask),
    .irq        (irq)
  );

  nfc_rstseq #(.CYCLES(RST_CYCLES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rst_start),
    .busy  (rst_busy)
  );

  assign ecc_clr = rst_busy;

  // read word capture and configuration register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_hold <= '0;
      ctrl_q  <= 12'h001;
    end else begin
      if (rd_valid) rd_hold <= rd_word;
      if (host_wr && host_addr == OFS_CTRL)
        ctrl_q <= {host_wdata[11:4], 2'b00, host_wdata[1:0]};
    end
  end

  assign cfg_page512 = ctrl_q[0];
  assign cfg_wide    = ctrl_q[1];
  assign cfg_rd_dly  = ctrl_q[7:4];
  assign cfg_wr_dly  = ctrl_q[11:8];

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFS_CTRL:   host_rdata = {4'h0, ctrl_q};
      OFS_STAT:   host_rdata = {11'h0, wb_empty, rd_pend, wr_pend, wb_full, dev_q};
      OFS_ISTAT:  host_rdata = {11'h0, irq_flags};
      OFS_IMASK:  host_rdata = {11'h0, irq_mask};
      OFS_RDWORD: host_rdata = rd_hold;
      OFS_RSTCTL: host_rdata = {15'h0, rst_busy};
      default:    host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/nfc_host_regs_chk.sv
module nfc_host_regs_chk #(
  parameter int DEPTH      = 4,
  parameter int RST_CYCLES = 4,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic          wb_full,
  input logic [CW-1:0] wb_count,
  input logic [4:0]    flags,
  input logic          ovf_ev,
  input logic          drain_ev,
  input logic          istat_we,
  input logic [4:0]    clr_bits,
  input logic          rst_start,
  input logic          rst_busy,
  input logic          dev_rdy,
  input logic          dev_q
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_run <= 0;
    else if (rst_busy) busy_run <= busy_run + 1;
    else               busy_run <= 0;
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && wb_full |=> wb_count <= $past(wb_count)); // R3

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && wb_full |=> flags[1]); // R3

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    32'(wb_count) <= DEPTH); // R3

  AST_DRAIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    drain_ev |=> flags[2]); // R4

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    istat_we && clr_bits[1] && !ovf_ev |=> !flags[1]); // R6

  AST_NBUSY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rdy && !dev_q |=> flags[0] && dev_q); // R8

  AST_RST_START: assert property (@(posedge clk) disable iff (!rst_n)
    rst_start && !rst_busy |=> rst_busy); // R10

  AST_RST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> busy_run < RST_CYCLES); // R10

endmodule

bind nfc_host_regs nfc_host_regs_chk #(.DEPTH(DEPTH), .RST_CYCLES(RST_CYCLES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_req  (push_req),
  .wb_full   (wb_full),
  .wb_count  (wb_count),
  .flags     (irq_flags),
  .ovf_ev    (ovf_ev),
  .drain_ev  (drain_ev),
  .istat_we  (istat_we),
  .clr_bits  (host_wdata[4:0]),
  .rst_start (rst_start),
  .rst_busy  (rst_busy),
  .dev_rdy   (dev_rdy),
  .dev_q     (dev_q)
);

// File: tb/nfc_host_regs_tb_top.sv
module nfc_host_regs_tb_top;
  localparam int DEPTH = 4;
  localparam int RSTC  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq;
  logic        dev_rdy = 1'b0;
  logic        cyc_valid;
  logic [1:0]  cyc_tag;
  logic [15:0] cyc_data;
  logic        cyc_pop = 1'b0;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_word = '0;
  logic        pg_rd_go, pg_wr_go;
  logic        pg_rd_done = 1'b0, pg_wr_done = 1'b0;
  logic        ecc_clr;
  logic        cfg_page512, cfg_wide;
  logic [3:0]  cfg_rd_dly, cfg_wr_dly;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nfc_host_regs #(.DEPTH(DEPTH), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .dev_rdy(dev_rdy), .cyc_valid(cyc_valid), .cyc_tag(cyc_tag),
    .cyc_data(cyc_data), .cyc_pop(cyc_pop), .rd_valid(rd_valid),
    .rd_word(rd_word), .pg_rd_go(pg_rd_go), .pg_wr_go(pg_wr_go),
    .pg_rd_done(pg_rd_done), .pg_wr_done(pg_wr_done), .ecc_clr(ecc_clr),
    .cfg_page512(cfg_page512), .cfg_wide(cfg_wide),
    .cfg_rd_dly(cfg_rd_dly), .cfg_wr_dly(cfg_wr_dly)
  );

  // expected status word from the requirement bit positions (R3, R8, R9)
  function automatic logic [15:0] exp_stat(input int n, input logic rdy,
                                           input logic wp, input logic rp);
    return {11'h0, n == 0, rp, wp, n >= DEPTH, rdy};
  endfunction

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // one register write: drive at falling edge, one rising edge, back at falling edge
  task automatic hw(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, output logic [15:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic pop1();
    @(negedge clk);
    cyc_pop = 1'b1;
    @(negedge clk);
    cyc_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] q_data[$];
    logic [1:0]  q_tag[$];
    logic        m_ovf;
    void'($urandom(32'h5eed));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hr(4'd1, v);  check("R1 status", v, 16'h0010);
    hr(4'd2, v);  check("R1 istat", v, 16'h0000);
    hr(4'd0, v);  check("R1 ctrl", v, 16'h0001);
    check("R1 irq/valid", {14'h0, irq, cyc_valid}, 16'h0);

    // R11 control fields
    hw(4'd0, 16'hFA5F);
    hr(4'd0, v);  check("R11 ctrl readback", v, 16'h0A53);
    check("R11 cfg outputs", {6'h0, cfg_wr_dly, cfg_rd_dly, cfg_wide, cfg_page512},
          {6'h0, 4'hA, 4'h5, 1'b1, 1'b1});

    // R2 / R3 fill buffer with one entry of each kind
    hw(4'd4, 16'h0090);
    check("R2 head after cmd", {cyc_valid, 5'h0, cyc_tag, cyc_data[7:0]}, 16'h8090);
    hw(4'd5, 16'h0012);
    hw(4'd6, 16'h00AB);
    hw(4'd7, 16'h0000);
    hr(4'd1, v);  check("R3 full status", v, exp_stat(4, 1'b0, 1'b0, 1'b0));
    hw(4'd6, 16'h0055);
    hr(4'd2, v);  check("R3 overflow flag", v, 16'h0002);
    check("R2 head kept cmd", {cyc_tag, cyc_data[13:0]}, {2'd0, 14'h0090});
    pop1(); check("R2 head addr", {cyc_tag, cyc_data[13:0]}, {2'd1, 14'h0012});
    pop1(); check("R2 head data-wr", {cyc_tag, cyc_data[13:0]}, {2'd2, 14'h00AB});
    pop1(); check("R2 head data-rd", {cyc_tag, cyc_data[13:0]}, {2'd3, 14'h0000});
    pop1();
    hr(4'd2, v);  check("R4 drain flag", v, 16'h0006);
    hr(4'd1, v);  check("R3 empty after drain", v, exp_stat(0, 1'b0, 1'b0, 1'b0));

    // R6 write-1-to-clear
    hw(4'd2, 16'h0002);
    hr(4'd2, v);  check("R6 clear bit1", v, 16'h0004);
    hw(4'd2, 16'h0000);
    hr(4'd2, v);  check("R6 zero leaves", v, 16'h0004);
    hw(4'd2, 16'h0004);
    hr(4'd2, v);  check("R6 clear bit2", v, 16'h0000);

    // R5 read word return
    @(negedge clk); rd_valid = 1'b1; rd_word = 16'hC33C;
    @(negedge clk); rd_valid = 1'b0;
    hr(4'd8, v);  check("R5 read word", v, 16'hC33C);
    hr(4'd2, v);  check("R5 ready flag", v, 16'h0008);

    // R7 masking
    check("R7 irq masked off", {15'h0, irq}, 16'h0);
    hw(4'd3, 16'h0008);
    check("R7 irq on", {15'h0, irq}, 16'h1);
    hw(4'd3, 16'h0010);
    check("R7 irq other mask", {15'h0, irq}, 16'h0);
    hw(4'd3, 16'h0008);

    // R6 set wins over same-cycle clear
    @(negedge clk);
    host_wr = 1'b1; host_addr = 4'd2; host_wdata = 16'h0008;
    rd_valid = 1'b1; rd_word = 16'h0077;
    @(negedge clk);
    host_wr = 1'b0; rd_valid = 1'b0;
    hr(4'd2, v);  check("R6 set wins", v, 16'h0008);
    hw(4'd2, 16'h0008);
    check("R7 irq after clear", {15'h0, irq}, 16'h0);

    // R8 ready line
    @(negedge clk); dev_rdy = 1'b1;
    @(negedge clk);
    hr(4'd1, v);  check("R8 status ready", v, exp_stat(0, 1'b1, 1'b0, 1'b0));
    hr(4'd2, v);  check("R8 not-busy flag", v, 16'h0001);
    hw(4'd2, 16'h0001);

    // R9 page write and read
    hw(4'd10, 16'h0002);
    check("R9 write go", {14'h0, pg_wr_go, pg_rd_go}, 16'h0002);
    hr(4'd1, v);  check("R9 write pending", v, exp_stat(0, 1'b1, 1'b1, 1'b0));
    @(negedge clk);
    check("R9 go one cycle", {14'h0, pg_wr_go, pg_rd_go}, 16'h0);
    pg_wr_done = 1'b1;
    @(negedge clk); pg_wr_done = 1'b0;
    hr(4'd1, v);  check("R9 write done status", v, exp_stat(0, 1'b1, 1'b0, 1'b0));
    hr(4'd2, v);  check("R9 write done flag", v, 16'h0010);
    hw(4'd2, 16'h0010);
    hw(4'd10, 16'h0001);
    check("R9 read go", {14'h0, pg_wr_go, pg_rd_go}, 16'h0001);
    hr(4'd1, v);  check("R9 read pending", v, exp_stat(0, 1'b1, 1'b0, 1'b1));
    @(negedge clk); pg_rd_done = 1'b1;
    @(negedge clk); pg_rd_done = 1'b0;
    hr(4'd1, v);  check("R9 read done status", v, exp_stat(0, 1'b1, 1'b0, 1'b0));

    // R10 self-clearing reset pulse
    hw(4'd9, 16'h0001);
    hr(4'd9, v);  check("R10 bit reads 1", v, 16'h0001);
    check("R10 clear pulse", {15'h0, ecc_clr}, 16'h1);
    repeat (RSTC - 1) @(negedge clk);
    hr(4'd9, v);  check("R10 still busy", {v[14:0], ecc_clr}, 16'h0003);
    @(negedge clk);
    hr(4'd9, v);  check("R10 cleared", {v[14:0], ecc_clr}, 16'h0000);

    // R2 / R3 / R4 constrained random against a queue model
    hw(4'd2, 16'h001F);
    m_ovf = 1'b0;
    for (int it = 0; it < 400; it++) begin
      logic do_w;
      logic [1:0] t;
      logic [15:0] d;
      logic pp;
      @(negedge clk);
      host_addr = 4'd1; #1;
      check("R3 rand status", host_rdata & 16'h0012,
            exp_stat(q_data.size(), 1'b0, 1'b0, 1'b0) & 16'h0012);
      check("R2 rand valid", {15'h0, cyc_valid}, {15'h0, q_data.size() != 0});
      if (q_data.size() != 0)
        check("R2 rand head", {cyc_tag, cyc_data[13:0]}, {q_tag[0], q_data[0][13:0]});
      host_addr = 4'd2; #1;
      check("R3 rand ovf", {15'h0, host_rdata[1]}, {15'h0, m_ovf});
      do_w = ($urandom % 100) < 55;
      t    = 2'($urandom);
      d    = 16'($urandom);
      pp   = (($urandom % 100) < 45) && cyc_valid;
      host_wr = do_w; host_addr = {2'b01, t}; host_wdata = d; cyc_pop = pp;
      if (do_w && q_data.size() >= DEPTH) m_ovf = 1'b1;
      if (pp) begin void'(q_data.pop_front()); void'(q_tag.pop_front()); end
      if (do_w && (q_data.size() + (pp ? 1 : 0)) < DEPTH + (pp ? 1 : 0)
          && !(q_data.size() + (pp ? 1 : 0) >= DEPTH)) begin
        q_data.push_back(d); q_tag.push_back(t);
      end
    end
    @(negedge clk);
    host_wr = 1'b0; cyc_pop = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule